// File: doc/BRIEF.md
# Infrared Receive Edge Timer with Burst Counter

This block is the receive half of an infrared timer. A two-flop synchronizer samples the receive pin, and an edge detector picks out the edges that the edge-select field allows. The first allowed edge arms the receiver and starts a 16-bit up-counter from zero. Each later allowed edge latches the counter into a capture register, latches the pin level, and raises the interrupt flag. With reload enabled, that edge also clears the counter, so each capture holds one interval. Without reload, the counter keeps running and each capture holds the total time since arming.

The counter advances on one of two time bases. It can step on every IR clock, or once per carrier period of (high byte + low byte + 2) IR clocks.

A burst mode turns the capture register into an edge counter for the marks of a modulated signal. Entering burst mode loads the register with one. In this mode the interrupt flag is raised when two carrier periods pass with no allowed edge, which marks the start of a space.

Flags are sticky and clear on a one-cycle pulse. No pin of this block carries a data stream, so it has no valid/ready interface. Every pin is a plain level, sampled each clock.

Top module: `ir_rx_capture`

## Requirements
- R1: The receiver is active only while `rx_en`=1 and `tx_mode`=0. The first allowed edge after activation arms it and sets the counter to 0. That edge updates neither `cap_q` nor `irq_flag`.
- R2: `edge_sel` encodes the allowed edges: 00 none, 01 rising only, 10 falling only, 11 both. An edge that is not allowed has no effect.
- R3: In normal mode, an allowed edge on an armed receiver copies the counter into `cap_q`, copies the synchronized pin level into `cap_level` (1 after a rising edge, 0 after a falling edge) and sets `irq_flag`. These outputs update on the third rising clock edge after the pin changes.
- R4: With `reload_en`=1, the edge that captures also clears the counter, so `cap_q` holds the interval since the previous allowed edge. With `reload_en`=0, the counter keeps running. With `clk_mode`=1, two edges N clocks apart give N-1.
- R5: With `clk_mode`=0, the counter steps once per carrier period of P = `car_hi` + `car_lo` + 2 IR clocks, so an N-clock interval captures floor((N-1)/P). With `clk_mode`=1, it steps on every IR clock.
- R6: A counter rollover from FFFFh to 0000h sets `ovf_flag`. It also sets `irq_flag` when `ovf_ie`=1.
- R7: With `burst_en`=1, each allowed edge after the arming edge adds one to `cap_q` instead of capturing, and does not set `irq_flag`. With reload enabled, that edge still clears the counter.
- R8: A 0-to-1 change of `burst_en` loads `cap_q` with 0001h. Arming the receiver and then seeing K-1 more edges therefore leaves `cap_q`=K.
- R9: In burst mode on an armed receiver, `irq_flag` is set when 2P IR clocks pass with no allowed edge. It is set on the 2P-th clock after the last edge, not before.
- R10: Clearing `rx_en` or setting `tx_mode` holds the counter at 0 and disarms the receiver. Pin edges then leave `cap_q`, `cap_level` and the flags unchanged.
- R11: A one-cycle `irq_clr` pulse clears both `irq_flag` and `ovf_flag`. A flag-setting event in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pin | input | 1 | Asynchronous infrared receive input |
| rx_en | input | 1 | Timer enable |
| tx_mode | input | 1 | 1 selects transmit, which stops receive |
| edge_sel | input | 2 | Allowed-edge select (see R2) |
| reload_en | input | 1 | Clear the counter on each capture edge |
| clk_mode | input | 1 | 0: count carrier periods, 1: count IR clocks |
| burst_en | input | 1 | Burst edge-count mode |
| car_hi | input | 8 | Carrier high time, in IR clocks minus one |
| car_lo | input | 8 | Carrier low time, in IR clocks minus one |
| ovf_ie | input | 1 | Rollover raises the interrupt flag |
| irq_clr | input | 1 | Clear pulse for both flags |
| cap_q | output | 16 | Capture register, or edge count in burst mode |
| cap_level | output | 1 | Pin level at the last counted edge |
| count_q | output | 16 | Running counter |
| irq_flag | output | 1 | Sticky interrupt flag |
| ovf_flag | output | 1 | Sticky rollover flag |

## Verification
Pin patterns with edges a fixed number of clocks apart are run with reload on and off. Because the expected value with reload off is the sum of intervals, reload on and reload off give different captures. The same spacing is repeated with the carrier-period time base. Its floor-divided result tells a period-based count from a per-clock count.

A rising-only run inserts a falling edge between two rising edges to show that unselected edges are dropped. A burst run first toggles the pin faster than two periods, then stops toggling. It checks the edge count, checks that no interrupt appears during the mark, and checks the flag one clock before and one clock after the 2P limit. A long idle run reaches the 16-bit rollover.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/ir_rx_sync_edge.sv
module ir_rx_sync_edge
  import ir_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_pin,
  input  logic [1:0] edge_sel,
  output logic       level,
  output logic       qual_edge
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] chain;
  logic         prev;
  logic         rise, fall;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= rx_pin;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[MSB-1:0], rx_pin};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[MSB];

  assign level = chain[MSB];
  assign rise  = chain[MSB] & ~prev;
  assign fall  = ~chain[MSB] & prev;

  always_comb begin
    unique case (edge_sel_e'(edge_sel))
      EDGE_RISE: qual_edge = rise;
      EDGE_FALL: qual_edge = fall;
      EDGE_BOTH: qual_edge = rise | fall;
      default:   qual_edge = 1'b0;
    endcase
  end
endmodule

// File: rtl/ir_rx_period.sv
module ir_rx_period #(
  parameter int PRESCALE = 1,
  parameter int PL_W     = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            clk_mode,
  input  logic [PL_W-1:0] plen,
  output logic            ir_tick,
  output logic            cnt_tick
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PL_W-1:0] phase;
  logic            period_end;

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign ir_tick = 1'b1;
    end else begin : g_div
      logic [PS_W-1:0] div;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                          div <= '0;
        else if (div == PS_W'(PRESCALE - 1)) div <= '0;
        else                                 div <= div + 1'b1;
      assign ir_tick = (div == PS_W'(PRESCALE - 1));
    end
  endgenerate

  assign period_end = (phase == plen - 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (ir_tick) phase <= period_end ? '0 : phase + 1'b1;

  assign cnt_tick = clk_mode ? ir_tick : (ir_tick & period_end);
endmodule

// File: rtl/ir_rx_gap.sv
module ir_rx_gap #(
  parameter int PL_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            run,
  input  logic            ir_tick,
  input  logic [PL_W-1:0] plen,
  output logic            timeout
);
  localparam int G_W = PL_W + 1;

  logic [G_W-1:0] gap;
  logic [G_W-1:0] limit;
  logic           done;

  assign limit   = {plen, 1'b0} - 1'b1;
  assign timeout = run & ir_tick & ~done & (gap == limit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gap  <= '0;
      done <= 1'b0;
    end else if (restart || !run) begin
      gap  <= '0;
      done <= 1'b0;
    end else if (ir_tick && !done) begin
      if (gap == limit) done <= 1'b1;
      else              gap  <= gap + 1'b1;
    end
endmodule

// File: rtl/ir_rx_capture.sv
module ir_rx_capture #(
  parameter int CNT_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int PRESCALE    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pin,
  input  logic              rx_en,
  input  logic              tx_mode,
  input  logic [1:0]        edge_sel,
  input  logic              reload_en,
  input  logic              clk_mode,
  input  logic              burst_en,
  input  logic [BYTE_W-1:0] car_hi,
  input  logic [BYTE_W-1:0] car_lo,
  input  logic              ovf_ie,
  input  logic              irq_clr,
  output logic [CNT_W-1:0]  cap_q,
  output logic              cap_level,
  output logic [CNT_W-1:0]  count_q,
  output logic              irq_flag,
  output logic              ovf_flag
);
  localparam int PL_W = BYTE_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic            level, qual_edge;
  logic            active, armed, burst_prev;
  logic            qe, arm_edge, next_edge, reload_hit, restart;
  logic            burst_entry, wrap, timeout;
  logic            ir_tick, cnt_tick;
  logic [PL_W-1:0] plen;

  assign plen = PL_W'(car_hi) + PL_W'(car_lo) + PL_W'(2);

  ir_rx_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk, .rst_n, .rx_pin, .edge_sel, .level, .qual_edge
  );

  assign active      = rx_en & ~tx_mode;
  assign qe          = qual_edge & active;
  assign arm_edge    = qe & ~armed;
  assign next_edge   = qe & armed;
  assign reload_hit  = next_edge & reload_en;
  assign restart     = arm_edge | reload_hit | ~active;
  assign burst_entry = burst_en & ~burst_prev;
  assign wrap        = active & armed & cnt_tick & ~reload_hit & (count_q == CNT_MAX);

  ir_rx_period #(.PRESCALE(PRESCALE), .PL_W(PL_W)) u_period (
    .clk, .rst_n, .restart, .clk_mode, .plen, .ir_tick, .cnt_tick
  );

  ir_rx_gap #(.PL_W(PL_W)) u_gap (
    .clk, .rst_n,
    .restart (arm_edge | next_edge),
    .run     (active & armed & burst_en),
    .ir_tick, .plen, .timeout
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed      <= 1'b0;
      burst_prev <= 1'b0;
    end else begin
      burst_prev <= burst_en;
      if (!active)       armed <= 1'b0;
      else if (arm_edge) armed <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      count_q <= '0;
    else if (!active || arm_edge)    count_q <= '0;
    else if (reload_hit)             count_q <= '0;
    else if (armed && cnt_tick)      count_q <= count_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_q     <= '0;
      cap_level <= 1'b0;
    end else begin
      if (burst_entry)    cap_q <= CNT_W'(1);
      else if (next_edge) cap_q <= burst_en ? cap_q + 1'b1 : count_q;
      if (next_edge)      cap_level <= level;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if ((next_edge && !burst_en) || timeout || (wrap && ovf_ie)) irq_flag <= 1'b1;
      else if (irq_clr)                                             irq_flag <= 1'b0;
      if (wrap)         ovf_flag <= 1'b1;
      else if (irq_clr) ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/ir_rx_capture_chk.sv
module ir_rx_capture_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             tx_mode,
  input logic [1:0]       edge_sel,
  input logic             burst_en,
  input logic             irq_clr,
  input logic [CNT_W-1:0] cap_q,
  input logic [CNT_W-1:0] count_q,
  input logic             ovf_flag
);
  a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en && !tx_mode) |=> (count_q == '0));

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !irq_clr) |=> ovf_flag);

  a_r2_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'b00) |=> ($stable(cap_q) || cap_q == CNT_W'(1)));

  a_r8_burst_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_en) |=> (cap_q == CNT_W'(1)));

  a_r7_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    burst_en |=> (cap_q == $past(cap_q) || cap_q == $past(cap_q) + CNT_W'(1)
                  || cap_q == CNT_W'(1)));
endmodule

bind ir_rx_capture ir_rx_capture_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_ir_rx_capture.sv
module tb_ir_rx_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_pin = 1'b0, rx_en = 1'b0, tx_mode = 1'b0;
  logic [1:0]  edge_sel = 2'b11;
  logic        reload_en = 1'b1, clk_mode = 1'b1, burst_en = 1'b0;
  logic [7:0]  car_hi = 8'd1, car_lo = 8'd1;
  logic        ovf_ie = 1'b0, irq_clr = 1'b0;
  logic [15:0] cap_q, count_q;
  logic        cap_level, irq_flag, ovf_flag;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ir_rx_capture dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pin change at a negedge; returns after n more negedges
  task automatic pin_hold(input logic v, input int n);
    rx_pin = v;
    cyc(n);
  endtask

  task automatic idle_clear();
    rx_en = 1'b0; burst_en = 1'b0; cyc(2);
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0; cyc(1);
  endtask

  task automatic t_reset();
    chk("R1 reset cap", cap_q, 0);
    chk("R1 reset count", count_q, 0);
    chk("R11 reset irq", irq_flag, 0);
    chk("R6 reset ovf", ovf_flag, 0);
  endtask

  task automatic t_reload();
    idle_clear(); edge_sel = 2'b11; reload_en = 1'b1; clk_mode = 1'b1;
    rx_en = 1'b1; cyc(2);
    pin_hold(1'b1, 10);                     // arming rise
    chk("R1 arm no capture", cap_q, 0);
    chk("R1 arm no irq", irq_flag, 0);
    pin_hold(1'b0, 3);                      // capture fall, 10 apart
    chk("R4 reload interval", cap_q, 9);
    chk("R3 level after fall", cap_level, 0);
    chk("R3 irq on capture", irq_flag, 1);
    cyc(4);                                  // next edge 7 after previous
    pin_hold(1'b1, 3);
    chk("R4 reload second interval", cap_q, 6);
    chk("R3 level after rise", cap_level, 1);
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    chk("R11 irq cleared", irq_flag, 0);
  endtask

  task automatic t_no_reload();
    idle_clear(); rx_pin = 1'b0; edge_sel = 2'b11; reload_en = 1'b0; clk_mode = 1'b1;
    cyc(3); rx_en = 1'b1; cyc(2);
    pin_hold(1'b1, 10);
    pin_hold(1'b0, 7);
    chk("R4 no reload first", cap_q, 9);
    pin_hold(1'b1, 3);
    chk("R4 no reload total", cap_q, 16);
  endtask

  task automatic t_rise_only();
    idle_clear(); rx_pin = 1'b0; edge_sel = 2'b01; reload_en = 1'b1; clk_mode = 1'b1;
    cyc(3); rx_en = 1'b1; cyc(2);
    pin_hold(1'b1, 5);
    pin_hold(1'b0, 6);
    chk("R2 falling ignored cap", cap_q, 16);
    chk("R2 falling ignored irq", irq_flag, 0);
    pin_hold(1'b1, 3);
    chk("R2 rising pair interval", cap_q, 10);
    chk("R2 rising level", cap_level, 1);
  endtask

  task automatic t_carrier();
    idle_clear(); rx_pin = 1'b0; edge_sel = 2'b11; reload_en = 1'b1;
    clk_mode = 1'b0; car_hi = 8'd1; car_lo = 8'd1;   // P = 4
    cyc(3); rx_en = 1'b1; cyc(2);
    pin_hold(1'b1, 20);
    pin_hold(1'b0, 3);
    chk("R5 carrier periods", cap_q, 4);
    cyc(5);                                   // 8 apart -> floor(7/4)=1
    pin_hold(1'b1, 3);
    chk("R5 carrier short", cap_q, 1);
    clk_mode = 1'b1;
  endtask

  task automatic t_stop();
    logic [15:0] held;
    held = cap_q;
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    tx_mode = 1'b1; cyc(2);
    pin_hold(1'b0, 5); pin_hold(1'b1, 5);
    chk("R10 tx stops capture", cap_q, held);
    chk("R10 tx count zero", count_q, 0);
    chk("R10 tx no irq", irq_flag, 0);
    tx_mode = 1'b0; rx_en = 1'b0;
    pin_hold(1'b0, 5); pin_hold(1'b1, 5);
    chk("R10 disable stops capture", cap_q, held);
    chk("R10 disable no irq", irq_flag, 0);
  endtask

  task automatic t_burst();
    idle_clear(); rx_pin = 1'b0; edge_sel = 2'b11; reload_en = 1'b1;
    clk_mode = 1'b0; car_hi = 8'd1; car_lo = 8'd1;   // 2P = 8
    cyc(3); rx_en = 1'b1; burst_en = 1'b1; cyc(2);
    chk("R8 burst load", cap_q, 1);
    for (int i = 0; i < 4; i++) pin_hold(~rx_pin, 3);
    pin_hold(~rx_pin, 3);                      // fifth edge, then quiet
    chk("R7 burst edge count", cap_q, 5);
    chk("R7 no irq during mark", irq_flag, 0);
    cyc(7);                                     // pin change + 10
    chk("R9 before two periods", irq_flag, 0);
    cyc(1);                                     // pin change + 11
    chk("R9 timeout raises irq", irq_flag, 1);
    chk("R9 count held", cap_q, 5);
    burst_en = 1'b0; clk_mode = 1'b1;
  endtask

  task automatic t_overflow();
    idle_clear(); rx_pin = 1'b0; edge_sel = 2'b11; clk_mode = 1'b1; ovf_ie = 1'b1;
    cyc(3); rx_en = 1'b1; cyc(2);
    pin_hold(1'b1, 65000);
    chk("R6 no early ovf", ovf_flag, 0);
    cyc(1000);
    chk("R6 ovf set", ovf_flag, 1);
    chk("R6 ovf irq", irq_flag, 1);
    rx_en = 1'b0;
    irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
    chk("R11 ovf cleared", ovf_flag, 0);
    chk("R11 irq cleared after ovf", irq_flag, 0);
  endtask

  initial begin : watchdog
    cyc(190000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(2);
    t_reset();
    t_reload();
    t_no_reload();
    t_rise_only();
    t_carrier();
    t_stop();
    t_burst();
    t_overflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule